// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides, slot by slot, who owns a shared bus: the CPU or one of two DMA channels. Each channel watches an external active-low request line. The line is captured on the falling clock edge. Detection is per channel, either on a high-to-low transition or on a low level. A short holdoff follows each detection, and detected requests wait out a fixed latency before they can win the bus. Requests queue in a small saturating counter inside each channel.

Each channel runs either one transfer per grant (cycle steal) or a run of transfers that keeps the bus until the channel's transfer count is used up (burst). When both channels want the bus, the winner comes from a fixed order or from a rotating order. A transfer is a fixed-length slot of `SLOT_LEN` cycles. A strobe marks the first cycle of every slot. A per-channel done flag rises when the channel's transfer count reaches zero. The count is loaded through a shared value bus.

When no channel qualifies, the bus belongs to the CPU. Out of scope: data movement, addresses, wait states and the bus cycle timing itself.

Top module: `dma_bus_arbiter`

## Requirements
- R1: A channel with level detection selected (`ch_level_i`=1) registers a request for every low sample that is not in holdoff. A channel with edge detection (`ch_level_i`=0) registers one request per high-to-low transition, however long the line stays low afterwards.
- R2: The request line is sampled on the falling clock edge. A low sample is detected at the following rising edge. With the bus free, the channel's grant appears at exactly the third rising edge after that detection edge.
- R3: After a detection, the sample taken one cycle later is ignored. A level-mode line held low for n falling-edge samples therefore yields ceil(n/2) requests. Up to 3 requests are queued per channel.
- R4: A cycle-steal channel (`ch_burst_i`=0) gets a single slot per grant. The next slot goes to another owner: the other channel if it qualifies, otherwise the CPU for one cycle.
- R5: With `rr_mode_i`=0, channel 0 wins whenever both channels qualify.
- R6: With `rr_mode_i`=1, the channel served most recently loses a tie. After reset, channel 0 wins the first tie.
- R7: A burst channel (`ch_burst_i`=1) that has won a slot keeps qualifying, with no further request, until its count reaches zero. The bus never returns to the CPU in between, in either priority mode. In rotating mode the other channel can interleave.
- R8: Each slot decrements the channel's count by one. `done_o` rises in the cycle that carries the strobe of the last transfer. A channel with count zero never receives a slot. A count load clears done and any queued requests.
- R9: A channel whose enable is low receives no slot and drops queued requests. Clearing enable during a burst ends the burst at the next slot boundary.
- R10: `grant_o` is one-hot: bit 0 is the CPU, bit 1 is channel 0, bit 2 is channel 1. It is 3'b001 after reset and whenever no channel qualifies. A channel grant lasts whole slots of `SLOT_LEN` cycles and changes only at slot ends. `xfer_stb_o[k]` pulses for exactly the first cycle of each channel-k slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_ni | input | 2 | Per-channel request lines, active low |
| ch_en_i | input | 2 | Per-channel enable |
| ch_level_i | input | 2 | 1: low-level detection, 0: falling-transition detection |
| ch_burst_i | input | 2 | 1: burst, 0: cycle steal |
| rr_mode_i | input | 1 | 1: rotating priority, 0: channel 0 first |
| cnt_load_i | input | 2 | Per-channel count load strobe |
| cnt_value_i | input | CNT_W | Count value for a load |
| grant_o | output | 3 | One-hot owner {ch1, ch0, cpu} |
| xfer_stb_o | output | 2 | Per-channel slot start strobe |
| done_o | output | 2 | Per-channel count-exhausted flag |

## Verification
The bench measures the cycle in which the grant first arrives after a request. A sampler or latency line that is one stage long or short shifts that cycle and is reported. It sweeps low-pulse lengths in both detection modes and compares the number of transfers with ceil(n/2) and with one. A missing holdoff would over-count, and broken edge detection would repeat transfers. It records the order of interleaved burst transfers under both priority modes: a bad rotation pointer reorders the sequence, and a burst that yields to the CPU shows CPU cycles mid-run. It also counts transfers after done and after an enable drop, where a wrong gate lets extra slots through.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH = 2;
  localparam int GNT_W  = NUM_CH + 1;
  localparam int GNT_CPU = 0;
endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int LAT      = 3,
  parameter int RESAMPLE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_ni,
  input  logic en_i,
  input  logic level_i,
  output logic pend_set_o
);
  localparam int HW = $clog2(RESAMPLE) + 1;
  localparam int DW = LAT - 1;

  logic          smp_q;
  logic          prev_q;
  logic [HW-1:0] hold_q;
  logic [DW-1:0] dl_q;
  logic          det;

  // capture on the falling edge of the bus clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= 1'b1;
    else         smp_q <= dreq_ni;
  end

  assign det = en_i && !smp_q && (level_i || prev_q) && (hold_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      hold_q <= '0;
    end else begin
      prev_q <= smp_q;
      if (det)                 hold_q <= HW'(RESAMPLE - 1);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  generate
    if (DW == 1) begin : g_dl_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dl_q <= '0;
        else         dl_q <= det;
      end
    end else begin : g_dl_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dl_q <= '0;
        else         dl_q <= {dl_q[DW-2:0], det};
      end
    end
  endgenerate

  assign pend_set_o = dl_q[DW-1] && en_i;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int CNT_W  = 8,
  parameter int PEND_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             burst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             pend_set_i,
  input  logic             start_i,
  output logic             req_o,
  output logic             hold_o,
  output logic             done_o
);
  localparam logic [PEND_W-1:0] PMAX = '1;
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              burst_q;
  logic              done_q;

  always_comb begin
    pend_d = pend_q;
    if (start_i && pend_d != '0)     pend_d = pend_d - 1'b1;
    if (pend_set_i && pend_d != PMAX) pend_d = pend_d + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pend_q  <= '0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      pend_q  <= '0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (!en_i) begin
      pend_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (start_i) begin
        cnt_q   <= cnt_q - 1'b1;
        burst_q <= burst_i && (cnt_q != ONE);
        if (cnt_q == ONE) done_q <= 1'b1;
      end
    end
  end

  assign hold_o = burst_q && burst_i;
  assign req_o  = en_i && (cnt_q != '0) && ((pend_q != '0) || hold_o);
  assign done_o = done_q;
endmodule

// File: rtl/dma_grant_arb.sv
module dma_grant_arb
  import dma_arb_pkg::*;
#(
  parameter int SLOT_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rr_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] hold_i,
  output logic [GNT_W-1:0]  grant_o,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] stb_o
);
  localparam int SW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

  logic [GNT_W-1:0]  grant_q, grant_d;
  logic [SW-1:0]     slot_q;
  logic [NUM_CH-1:0] stb_q;
  logic [NUM_CH-1:0] mask, elig, win;
  logic              last_q;
  logic              boundary;

  assign boundary = grant_q[GNT_CPU] || (slot_q == SW'(SLOT_LEN - 1));

  // a cycle-steal owner sits out the next decision; a continuing burst does not
  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_mask
      assign mask[k] = grant_q[k+1] && !hold_i[k];
    end
  endgenerate

  assign elig = req_i & ~mask;

  always_comb begin
    win = elig;
    if (elig == 2'b11) win = (rr_i && !last_q) ? 2'b10 : 2'b01;
  end

  assign start_o = boundary ? win : '0;
  assign grant_d = boundary ? {win, ~|win} : grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= GNT_W'(1);
      slot_q  <= '0;
      stb_q   <= '0;
      last_q  <= 1'b1;
    end else begin
      grant_q <= grant_d;
      slot_q  <= boundary ? '0 : slot_q + 1'b1;
      stb_q   <= start_o;
      if (|start_o) last_q <= start_o[1];
    end
  end

  assign grant_o = grant_q;
  assign stb_o   = stb_q;
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PEND_W   = 2,
  parameter int SLOT_LEN = 4,
  parameter int LAT      = 3,
  parameter int RESAMPLE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] dreq_ni,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_level_i,
  input  logic [NUM_CH-1:0] ch_burst_i,
  input  logic              rr_mode_i,
  input  logic [NUM_CH-1:0] cnt_load_i,
  input  logic [CNT_W-1:0]  cnt_value_i,
  output logic [GNT_W-1:0]  grant_o,
  output logic [NUM_CH-1:0] xfer_stb_o,
  output logic [NUM_CH-1:0] done_o
);
  logic [NUM_CH-1:0] pend_set, req, hold, start;

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      dma_req_sampler #(.LAT(LAT), .RESAMPLE(RESAMPLE)) u_smp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .dreq_ni   (dreq_ni[k]),
        .en_i      (ch_en_i[k]),
        .level_i   (ch_level_i[k]),
        .pend_set_o(pend_set[k])
      );

      dma_chan_ctrl #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_ctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (ch_en_i[k]),
        .burst_i   (ch_burst_i[k]),
        .load_i    (cnt_load_i[k]),
        .load_val_i(cnt_value_i),
        .pend_set_i(pend_set[k]),
        .start_i   (start[k]),
        .req_o     (req[k]),
        .hold_o    (hold[k]),
        .done_o    (done_o[k])
      );
    end
  endgenerate

  dma_grant_arb #(.SLOT_LEN(SLOT_LEN)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rr_i   (rr_mode_i),
    .req_i  (req),
    .hold_i (hold),
    .grant_o(grant_o),
    .start_o(start),
    .stb_o  (xfer_stb_o)
  );
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk #(
  parameter int SLOT_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ch_en_i,
  input logic [1:0] ch_burst_i,
  input logic [2:0] grant_o,
  input logic [1:0] xfer_stb_o,
  input logic [1:0] done_o
);
  localparam int RW = $clog2(SLOT_LEN) + 1;
  localparam logic [RW-1:0] LAST = RW'(SLOT_LEN - 1);

  logic [RW-1:0] run_q, pos_c;

  assign pos_c = (|xfer_stb_o) ? '0 : run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (pos_c == LAST) run_q <= pos_c;
    else                    run_q <= pos_c + 1'b1;
  end

  a_r10_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == 1);

  a_r10_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_o[0] && pos_c < LAST) |=> (grant_o == $past(grant_o)) && (xfer_stb_o == 2'b00));

  generate
    for (genvar k = 0; k < 2; k++) begin : g_ch
      a_r10_stb_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_stb_o[k] |-> grant_o[k+1]);

      a_r4_steal_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o[k+1] && !ch_burst_i[k] && pos_c == LAST) |=> !grant_o[k+1]);

      a_r9_disabled_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ch_en_i[k] |=> !xfer_stb_o[k]);

      a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o[k] && $past(done_o[k])) |-> !xfer_stb_o[k]);
    end
  endgenerate
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.SLOT_LEN(SLOT_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ch_en_i   (ch_en_i),
  .ch_burst_i(ch_burst_i),
  .grant_o   (grant_o),
  .xfer_stb_o(xfer_stb_o),
  .done_o    (done_o)
);

// File: tb/dma_bus_arbiter_bench.sv
module dma_bus_arbiter_bench;
  localparam int CNT_W    = 8;
  localparam int SLOT_LEN = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       dreq_n = 2'b11;
  logic [1:0]       ch_en = 2'b00, ch_level = 2'b00, ch_burst = 2'b00;
  logic             rr_mode = 1'b0;
  logic [1:0]       cnt_load = 2'b00;
  logic [CNT_W-1:0] cnt_value = '0;
  logic [2:0]       grant;
  logic [1:0]       stb, done;

  int nchk = 0, nfail = 0;
  int st_cnt[2];
  int seq, nstb, cpu_mid, gap_viol;
  bit seen0, cpu_since0;

  always #10 clk = ~clk;

  dma_bus_arbiter #(.CNT_W(CNT_W), .SLOT_LEN(SLOT_LEN)) u_dma_bus_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .dreq_ni(dreq_n), .ch_en_i(ch_en),
    .ch_level_i(ch_level), .ch_burst_i(ch_burst), .rr_mode_i(rr_mode),
    .cnt_load_i(cnt_load), .cnt_value_i(cnt_value),
    .grant_o(grant), .xfer_stb_o(stb), .done_o(done));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear_mon();
    st_cnt[0] = 0; st_cnt[1] = 0;
    seq = 0; nstb = 0; cpu_mid = 0; gap_viol = 0;
    seen0 = 0; cpu_since0 = 0;
  endtask

  task automatic cfg(int ch, bit en, bit lvl, bit bst, int cnt);
    ch_en[ch] = en; ch_level[ch] = lvl; ch_burst[ch] = bst;
    cnt_value = CNT_W'(cnt);
    cnt_load[ch] = 1'b1;
    tick(1);
    cnt_load[ch] = 1'b0;
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      nchk++;
      if ($countones(grant) != 1) begin
        nfail++;
        $display("FAIL R10 grant not one-hot act=%0d exp=1", $countones(grant));
      end
      if (grant[0]) begin
        cpu_since0 = 1;
        if (nstb > 0 && nstb < 6) cpu_mid++;
      end
      for (int k = 0; k < 2; k++) begin
        if (stb[k]) begin
          st_cnt[k]++;
          nstb++;
          seq = (seq << 1) | k;
          if (k == 0) begin
            if (seen0 && !cpu_since0) gap_viol++;
            seen0 = 1; cpu_since0 = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    report();
    $finish;
  end

  initial begin
    int k;
    clear_mon();
    tick(3);
    // R10 reset state
    chk("R10 reset grant", grant, 3'b001);
    chk("R10 reset strobe", stb, 0);
    chk("R8 reset done", done, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 latency: edge mode, single transfer
    cfg(0, 1, 0, 0, 1);
    tick(3);
    clear_mon();
    dreq_n[0] = 1'b0;
    k = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1); k++;
      if (grant[1]) break;
    end
    chk("R2 edges to grant", k, 4);
    chk("R10 strobe at slot start", stb, 2'b01);
    chk("R8 done with last strobe", done[0], 1);
    tick(SLOT_LEN - 1);
    chk("R10 slot length held", grant, 3'b010);
    tick(1);
    chk("R10 cpu after slot", grant, 3'b001);
    dreq_n[0] = 1'b1;
    tick(20);
    chk("R8 no transfer at zero count", st_cnt[0], 1);

    // R1 / R3 sweep: pulse lengths in both detection modes
    for (int m = 0; m < 2; m++) begin
      for (int n = 1; n <= 6; n++) begin
        cfg(0, 1, m[0], 0, 8);
        tick(6);
        clear_mon();
        dreq_n[0] = 1'b0;
        tick(n);
        dreq_n[0] = 1'b1;
        tick(60);
        if (m == 0) chk("R1 edge mode one request", st_cnt[0], 1);
        else        chk("R3 holdoff ceil(n/2)", st_cnt[0], (n + 1) / 2);
      end
    end

    // R4 / R8 level mode held low, cycle steal
    cfg(0, 1, 1, 0, 3);
    tick(4);
    clear_mon();
    dreq_n[0] = 1'b0;
    tick(80);
    chk("R8 transfers equal count", st_cnt[0], 3);
    chk("R8 done set", done[0], 1);
    chk("R4 cpu between steal slots", gap_viol, 0);
    tick(40);
    chk("R8 quiet after done", st_cnt[0], 3);
    cfg(0, 1, 1, 0, 1);
    chk("R8 load clears done", done[0], 0);
    tick(40);
    chk("R8 reload one more", st_cnt[0], 4);
    chk("R8 done again", done[0], 1);
    dreq_n[0] = 1'b1;
    tick(10);

    // R5 / R7 fixed priority, both burst
    rr_mode = 1'b0;
    cfg(0, 1, 0, 1, 3);
    cfg(1, 1, 0, 1, 3);
    tick(4);
    clear_mon();
    dreq_n = 2'b00;
    tick(60);
    dreq_n = 2'b11;
    chk("R5 fixed order", seq, 7);
    chk("R7 burst count fixed", nstb, 6);
    chk("R7 no cpu mid burst fixed", cpu_mid, 0);

    // R6 / R7 rotating priority, both burst (ch1 served last)
    rr_mode = 1'b1;
    cfg(0, 1, 0, 1, 3);
    cfg(1, 1, 0, 1, 3);
    tick(4);
    clear_mon();
    dreq_n = 2'b00;
    tick(60);
    dreq_n = 2'b11;
    chk("R6 rotating order", seq, 21);
    chk("R7 burst count rotating", nstb, 6);
    chk("R7 no cpu mid burst rotating", cpu_mid, 0);
    rr_mode = 1'b0;

    // R9 enable cleared mid-burst
    cfg(0, 0, 1, 0, 5);
    cfg(1, 1, 0, 1, 10);
    tick(4);
    clear_mon();
    dreq_n[1] = 1'b0;
    while (st_cnt[1] < 2) tick(1);
    ch_en[1] = 1'b0;
    tick(40);
    dreq_n[1] = 1'b1;
    chk("R9 burst ends at boundary", st_cnt[1], 2);
    chk("R9 grant back to cpu", grant, 3'b001);
    chk("R9 done stays low", done[1], 0);

    // R9 disabled channel ignores its request line
    clear_mon();
    dreq_n[0] = 1'b0;
    tick(30);
    chk("R9 disabled no transfer", st_cnt[0], 0);
    chk("R9 disabled grant cpu", grant, 3'b001);
    dreq_n[0] = 1'b1;
    tick(4);

    report();
    $finish;
  end
endmodule